// File: doc/BRIEF.md
# MDIO Management Command Controller

This block runs single management transactions on the two-wire PHY management bus. Software writes a 16-bit value into a write-data register when it needs one. It then writes a command word that names the PHY address and the register number and sets either a read bit or a write bit. The controller builds the 64-bit management frame and shifts it out MSB first on the MDC/MDIO pins. MDC is derived from the system clock by an even divider.

The command bit stays set for the whole transaction, and software polls it. When the frame ends the bit clears itself. After a read, the 16 bits taken from the PHY sit in the low half of the same command register. A command word written while a transaction is running is dropped. MDC is held low between transactions, and MDIO is released then.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command register reads zero, MDC is low and the MDIO output enable is low.
- R2: Command register layout: bit 27 is the write command, bit 26 is the read command, bits 25:21 are the register number, bits 20:16 are the PHY address and bits 15:0 hold read data. Bits 31:28 read zero. If bits 26 and 27 are both written as one, only the read command is kept and a read is performed.
- R3: A write sends 32 ones, start 01, opcode 01, the PHY address, the register number, turnaround 10 and the 16 write-data bits, all MSB first. The output enable is high for all 64 bits, and each bit spans one MDC period.
- R4: A read sends opcode 10 and drives the first 46 bits. The output enable goes low from the turnaround (bit 46) to the end of the frame.
- R5: During a read the controller samples MDIO on the MDC rising edges of frame bits 48 to 63, MSB first. The 16-bit result appears in bits 15:0 of the command register when the command bit clears.
- R6: The command bit stays set while the frame is in progress. It clears after the falling MDC edge that follows the 64th rising edge.
- R7: A read of a PHY address with no device, where the input is left pulled up, returns 16'hFFFF.
- R8: While a frame runs, the MDC period is CLK_DIV system clocks, with CLK_DIV/2 high and CLK_DIV/2 low. CLK_DIV is even and at least 4. Between frames MDC stays low.
- R9: A command-register write while the command bit is set has no effect on the register fields or on the frame in progress.
- R10: The write-data register (select 1, bits 15:0) is captured when a write command starts. Changing it during a frame does not alter that frame. A write transaction leaves command bits 15:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects the command register, 1 the write-data register |
| csr_wdata | input | 32 | Register write value |
| cmd_q | output | 32 | Command register contents, including busy bits and read data |
| wdata_q | output | 16 | Write-data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench sweeps all 32 PHY addresses with both reads and writes. A PHY model captures every bit on MDC rising edges and answers reads. Each frame and each read result is compared against a value computed arithmetically, which catches a field placed in the wrong position, a turnaround not released (the enable would stay high in bits 46–47), and data sampled one bit early or late (the result would be shifted). The empty address shows whether a pull-up input really yields all ones. Separate cases cover a command and a write-data update issued in the middle of a frame, where a design that accepted them would corrupt the frame or the register fields. They also cover a command with both bits set and the MDC period, which a wrong divider would stretch or shrink.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;
  localparam int FLD_W     = 5;
  localparam int DATA_W    = 16;
  localparam int CMD_WR_B  = 27;
  localparam int CMD_RD_B  = 26;
  localparam int REG_LSB   = 21;
  localparam int ADDR_LSB  = 16;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic rd, input logic [FLD_W-1:0] pa,
    input logic [FLD_W-1:0] rn, input logic [DATA_W-1:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, rn,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : d)};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt       <= '0;
      mdc       <= 1'b0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else begin
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      if (cnt == LAST) begin
        cnt       <= '0;
        mdc       <= ~mdc;
        rise_tick <= ~mdc;
        fall_tick <= mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc); // R8
  AST_TICK_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_tick, fall_tick})); // R8
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_rd,
  input  logic [FLD_W-1:0]  phy_addr,
  input  logic [FLD_W-1:0]  reg_num,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              run,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              done_rd,
  output logic [DATA_W-1:0] rd_data
);
  localparam int BW = $clog2(FRAME_LEN) + 1;
  localparam logic [BW-1:0] END_CNT  = BW'(FRAME_LEN);
  localparam logic [BW-1:0] TA_CNT   = BW'(TA_IDX);
  localparam logic [BW-1:0] SAMP_CNT = BW'(DATA_IDX + 1);

  logic [FRAME_LEN-1:0] shreg;
  logic [BW-1:0]        bit_cnt;  // bits driven so far
  logic                 is_rd;
  logic [FRAME_LEN-1:0] frame;

  always_comb frame = build_frame(start_rd, phy_addr, reg_num, wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '1;
      bit_cnt <= '0;
      is_rd   <= 1'b0;
      run     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      done_rd <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (start && !run) begin
        mdio_o  <= frame[FRAME_LEN-1];
        shreg   <= {frame[FRAME_LEN-2:0], 1'b1};
        mdio_oe <= 1'b1;
        bit_cnt <= BW'(1);
        run     <= 1'b1;
        is_rd   <= start_rd;
      end else if (run && rise_tick) begin
        if (is_rd && bit_cnt >= SAMP_CNT)
          rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end else if (run && fall_tick) begin
        if (bit_cnt == END_CNT) begin
          run     <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
          done    <= 1'b1;
          done_rd <= is_rd;
        end else begin
          mdio_o  <= shreg[FRAME_LEN-1];
          shreg   <= {shreg[FRAME_LEN-2:0], 1'b1};
          mdio_oe <= !(is_rd && bit_cnt >= TA_CNT);
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  AST_TA_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (run && is_rd && bit_cnt > TA_CNT) |-> !mdio_oe); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run |-> !mdio_oe); // R1
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> !run); // R6
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        csr_we,
  input  logic        csr_sel,
  input  logic [31:0] csr_wdata,
  output logic [31:0] cmd_q,
  output logic [15:0] wdata_q,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              rd_bit, wr_bit;
  logic [FLD_W-1:0]  addr_f, reg_f;
  logic [DATA_W-1:0] rdat_f;
  logic              busy, cmd_wr, start, start_rd;
  logic              run, rise_tick, fall_tick, done, done_rd;
  logic [DATA_W-1:0] seq_rdata;
  logic              unused_bits;

  assign unused_bits = ^{csr_wdata[31:28]};
  assign busy     = rd_bit | wr_bit;
  assign cmd_wr   = csr_we && !csr_sel;
  assign start_rd = csr_wdata[CMD_RD_B];
  assign start    = cmd_wr && !busy && (csr_wdata[CMD_RD_B] || csr_wdata[CMD_WR_B]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bit  <= 1'b0;
      wr_bit  <= 1'b0;
      addr_f  <= '0;
      reg_f   <= '0;
      rdat_f  <= '0;
      wdata_q <= '0;
    end else begin
      if (csr_we && csr_sel)
        wdata_q <= csr_wdata[DATA_W-1:0];
      if (done) begin
        rd_bit <= 1'b0;
        wr_bit <= 1'b0;
        if (done_rd) rdat_f <= seq_rdata;
      end else if (cmd_wr && !busy) begin
        rd_bit <= csr_wdata[CMD_RD_B];
        wr_bit <= csr_wdata[CMD_WR_B] & ~csr_wdata[CMD_RD_B];
        addr_f <= csr_wdata[ADDR_LSB +: FLD_W];
        reg_f  <= csr_wdata[REG_LSB +: FLD_W];
      end
    end
  end

  assign cmd_q = {4'b0000, wr_bit, rd_bit, reg_f, addr_f, rdat_f};

  mdio_clk_div #(.CLK_DIV(CLK_DIV)) clk_div_i (
    .clk(clk), .rst(rst), .en(run),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq seq_i (
    .clk(clk), .rst(rst), .start(start), .start_rd(start_rd),
    .phy_addr(csr_wdata[ADDR_LSB +: FLD_W]), .reg_num(csr_wdata[REG_LSB +: FLD_W]),
    .wr_data(wdata_q), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .run(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .done_rd(done_rd), .rd_data(seq_rdata)
  );

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> ($stable(addr_f) && $stable(reg_f))); // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy); // R6
  AST_BUSY_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    run |-> busy); // R6
  AST_ONE_CMD_BIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_bit, wr_bit})); // R2
  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (done && !done_rd) |=> $stable(rdat_f)); // R10
endmodule

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam logic [4:0] NODEV = 5'd31;

  logic clk = 1'b0, rst = 1'b1;
  logic csr_we = 1'b0, csr_sel = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] cmd_q;
  logic [15:0] wdata_q;
  logic mdc, mdio_o, mdio_oe, mdio_in;
  logic phy_drv = 1'b1;

  int errors = 0, checks = 0, nbits = 0;
  logic [63:0] cap = '0, capoe = '0;
  logic resp_en = 1'b0;
  logic [15:0] resp_val = '0;
  logic [15:0] last_rd = '0;
  logic [15:0] wd_model = '0;
  time t_r0 = 0, t_r1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mdio_in = mdio_oe ? mdio_o : phy_drv;

  mdio_cmd_ctrl #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .cmd_q(cmd_q), .wdata_q(wdata_q), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_in)
  );

  always @(posedge mdc) begin
    if (nbits == 0) t_r0 = $time;
    if (nbits == 1) t_r1 = $time;
    cap   = {cap[62:0], mdio_o};
    capoe = {capoe[62:0], mdio_oe};
    nbits = nbits + 1;
  end

  always @(negedge mdc) begin
    if (resp_en && nbits >= 48 && nbits < 64) phy_drv = resp_val[63-nbits];
    else phy_drv = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic sel, input logic [31:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  function automatic logic [31:0] cmd_word(input logic rd, input logic wr,
                                           input logic [4:0] pa, input logic [4:0] rn);
    return {4'b0, wr, rd, rn, pa, 16'h0};
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cmd_q[27:26] == 2'b00) break;
    end
  endtask

  task automatic check_frame(input string req, input logic rd, input logic [4:0] pa,
                             input logic [4:0] rn, input logic [15:0] wd);
    logic [63:0] exp, mask;
    exp  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, rn, 2'b10, wd};
    mask = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    chk({req, " bit count"}, 64'(nbits), 64'd64);
    chk({req, " frame bits"}, cap & mask, exp & mask);
    chk({req, " output enable"}, capoe, mask);
  endtask

  task automatic txn(input logic rd, input logic wr, input logic [4:0] pa,
                     input logic [4:0] rn, input logic [15:0] wd);
    logic eff_rd;
    logic [15:0] resp;
    eff_rd = rd;
    resp = 16'((pa * 16'd2053) ^ (rn << 5) ^ 16'h3C96);
    if (!eff_rd) begin
      csr_write(1'b1, {16'hDEAD, wd});
      wd_model = wd;
    end
    resp_en = eff_rd && (pa != NODEV);
    resp_val = resp;
    nbits = 0;
    csr_write(1'b0, cmd_word(rd, wr, pa, rn) | 32'h0000_5A5A);
    repeat (32 * DIV) @(negedge clk);
    chk("R6 bit held mid-frame", 64'(cmd_q[27:26]), eff_rd ? 64'd1 : 64'd2);
    wait_idle();
    check_frame(eff_rd ? "R4 read" : "R3 write", eff_rd, pa, rn, wd_model);
    if (eff_rd) last_rd = (pa == NODEV) ? 16'hFFFF : resp;
    chk(eff_rd ? ((pa == NODEV) ? "R7 no-device read" : "R5 read result") : "R10 write keeps low half",
        64'(cmd_q), 64'({4'b0, 2'b00, rn, pa, last_rd}));
    chk("R8 MDC idle low", 64'({mdc, mdio_oe}), 64'd0);
    resp_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset cmd", 64'(cmd_q), 64'd0);
    chk("R1 reset pins", 64'({mdc, mdio_oe}), 64'd0);

    for (int a = 0; a < 32; a++) begin
      txn(1'b0, 1'b1, 5'(a), 5'((a * 7 + 3) % 32), 16'((a * 16'h0F1D) ^ 16'hA50F));
      txn(1'b1, 1'b0, 5'(a), 5'((a * 11 + 5) % 32), 16'h0);
    end

    // R8 MDC period measured across the last frame
    chk("R8 MDC period", 64'(t_r1 - t_r0), 64'(DIV * CLK_PERIOD));

    // R2 both command bits set -> read
    txn(1'b1, 1'b1, 5'd9, 5'd2, 16'h0);

    // R9 and R10: command and write-data update during a busy frame
    csr_write(1'b1, 32'h0000_1234);
    wd_model = 16'h1234;
    nbits = 0;
    csr_write(1'b0, cmd_word(1'b0, 1'b1, 5'd6, 5'd17));
    repeat (10 * DIV) @(negedge clk);
    csr_write(1'b0, cmd_word(1'b1, 1'b0, 5'd20, 5'd3));
    csr_write(1'b1, 32'h0000_FFFF);
    @(negedge clk);
    chk("R9 fields held during busy", 64'(cmd_q[27:16]), 64'({2'b10, 5'd17, 5'd6}));
    wait_idle();
    check_frame("R9/R10 busy frame", 1'b0, 5'd6, 5'd17, 16'h1234);
    chk("R9 register after busy frame", 64'(cmd_q), 64'({6'b0, 5'd17, 5'd6, last_rd}));
    chk("R10 write-data register updated", 64'(wdata_q), 64'h0000_0000_0000_FFFF);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule